// File: doc/BRIEF.md
# Refill Line Buffer

This block is a one-line staging buffer on the refill path of a data cache. When a refill starts, the beats arriving from the bus are captured into the buffer, and the critical beat is handed to the CPU in the same cycle it arrives. The cache array is not written while the refill runs. The completed line stays in the buffer and answers later lookups. Only when the next refill begins is the buffered line copied into the array, in a single cycle before the first new beat lands. Allocation therefore never adds latency to the miss that caused it.

A static configuration input, `cache_en`, selects the mode. With `cache_en` high, a cache array is present: its tag-compare result arrives on `arr_hit`, and the buffered line is always pushed into it on replacement. With `cache_en` low, there is no array and the buffer acts as a one-line cache. In that mode `arr_hit` is ignored, a clean line is simply dropped on replacement, and only a modified line is presented on the line write port as a writeback.

The controller has four states. EMPTY holds no line. HOLD holds a complete, valid line. XFER is the single cycle in which the old line is driven on the line write port. FILL is the state in which beats are captured. The transitions are:

- START_EMPTY: EMPTY to FILL, on `fill_start`.
- START_PUSH: HOLD to XFER, on `fill_start` when `cache_en` is high or the line is dirty.
- START_DROP: HOLD to FILL, on `fill_start` when `cache_en` is low and the line is clean.
- PUSH_DONE: XFER to FILL, always after one cycle.
- LAST_BEAT: FILL to HOLD, on the final beat.

Top module: `refill_line_buffer`

## Requirements
- R1: After reset the buffer holds no line. `busy`, `line_wr_en` and `fwd_valid` are 0, and no lookup reports `lk_buf_hit`.
- R2: A refill at word address {tag, c} delivers four beats. Beat k is written to word (c+k) mod 4. After the last beat, a cacheable read of any word of that tag returns the beat stored there on `lk_rdata`, in the same cycle as the lookup.
- R3: `fwd_valid` is 1 in exactly the cycle the first beat of a refill is presented, with `fwd_data` equal to that beat. It is 0 for the other beats.
- R4: `line_wr_en` is 0 in every cycle in which a refill beat is captured.
- R5: With `cache_en`=1, a `fill_start` while a line is held raises `line_wr_en` for exactly the next cycle. In that cycle the port carries the old tag, the old line (word i in bits [32i+31:32i]) and the old dirty state. The first beat is then accepted one cycle later.
- R6: A cacheable lookup whose tag matches the held line sets `lk_buf_hit`=1 and `lk_miss`=0, whatever the value of `arr_hit`. Otherwise `lk_miss` = cacheable and not (`cache_en` and `arr_hit`).
- R7: A non-cacheable lookup never sets `lk_buf_hit` or `lk_miss`.
- R8: A write that hits the buffer replaces the addressed word and marks the line dirty. The dirty state appears on `line_wr_dirty` when the line is pushed out.
- R9: With `cache_en`=0, `arr_hit` has no effect on `lk_miss`. Replacing a clean line produces no `line_wr_en`, and the first beat is accepted in the cycle after `fill_start`. Replacing a dirty line produces the one-cycle push of R5.
- R10: A write lookup that does not hit the buffer leaves all four held words unchanged.
- R11: `busy` is 1 from the cycle after `fill_start` until the last beat is captured. No lookup hits the buffer while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_en | input | 1 | 1 = cache array present, 0 = buffer acts as one-line cache |
| lk_valid | input | 1 | Lookup request valid |
| lk_write | input | 1 | Lookup is a word write |
| lk_cacheable | input | 1 | Lookup address is cacheable |
| lk_waddr | input | WADDR_W | Word address: low 2 bits word index, upper bits tag |
| lk_wdata | input | WORD_W | Write data |
| arr_hit | input | 1 | Tag-compare result from the cache array |
| lk_buf_hit | output | 1 | Lookup hits the buffered line |
| lk_miss | output | 1 | Lookup misses both buffer and array |
| lk_rdata | output | WORD_W | Read data on a buffer hit, else 0 |
| fill_start | input | 1 | A refill begins; address on fill_waddr |
| fill_waddr | input | WADDR_W | Refill word address; low bits give the critical word |
| fill_valid | input | 1 | Refill beat valid |
| fill_data | input | WORD_W | Refill beat data |
| fwd_valid | output | 1 | Critical beat forwarded to the CPU |
| fwd_data | output | WORD_W | Forwarded beat |
| busy | output | 1 | Push or refill in progress |
| line_wr_en | output | 1 | Write held line into the array or out as writeback |
| line_wr_tag | output | TAG_W | Tag of the line being written |
| line_wr_data | output | LINE_W | Line being written, word i in bits [32i+31:32i] |
| line_wr_dirty | output | 1 | Line being written is modified |

## Verification
The assertions assume that `cache_en` changes only while no refill or push is in progress. They also assume that `fill_start` is raised only while `busy` is low, that `fill_valid` is held low until the controller reaches FILL, and that a write lookup never coincides with `fill_start`. The stimulus drives all inputs on falling edges. It starts each refill from an idle buffer and waits out the push cycle before sending beats. It toggles `cache_en` only between refills, and it keeps lookups in cycles of their own, apart from one deliberate read during a refill.

// File: rtl/rlb_pkg.sv
package rlb_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_HOLD  = 2'd1,
        ST_XFER  = 2'd2,
        ST_FILL  = 2'd3
    } rlb_state_e;
endpackage

// File: rtl/rlb_ctrl.sv
module rlb_ctrl
    import rlb_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int CNT_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cache_en,
    input  logic             fill_start,
    input  logic             fill_valid,
    input  logic             line_dirty,
    output logic [CNT_W-1:0] beat_cnt,
    output logic             start_ok,
    output logic             beat_we,
    output logic             commit,
    output logic             xfer_en,
    output logic             fwd_valid,
    output logic             busy,
    output logic             hold
);
    rlb_state_e state_q, state_d;
    logic       last_beat;

    assign last_beat = (beat_cnt == CNT_W'(WORDS - 1));
    assign start_ok  = fill_start && (state_q == ST_EMPTY || state_q == ST_HOLD);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (start_ok) state_d = ST_FILL;
            ST_HOLD:  if (start_ok) state_d = (cache_en || line_dirty) ? ST_XFER : ST_FILL;
            ST_XFER:  state_d = ST_FILL;
            ST_FILL:  if (fill_valid && last_beat) state_d = ST_HOLD;
        endcase
    end

    // beat counter
    always_ff @(posedge clk) begin
        if (!rst_n)                              beat_cnt <= '0;
        else if (start_ok)                       beat_cnt <= '0;
        else if (state_q == ST_FILL && fill_valid)
            beat_cnt <= last_beat ? '0 : beat_cnt + CNT_W'(1);
    end

    // outputs
    always_comb begin
        beat_we   = 1'b0;
        xfer_en   = 1'b0;
        busy      = 1'b0;
        hold      = 1'b0;
        unique case (state_q)
            ST_EMPTY: ;
            ST_HOLD:  hold = 1'b1;
            ST_XFER:  begin xfer_en = 1'b1; busy = 1'b1; end
            ST_FILL:  begin beat_we = fill_valid; busy = 1'b1; end
        endcase
        commit    = beat_we && last_beat;
        fwd_valid = beat_we && (beat_cnt == '0);
    end
endmodule

// File: rtl/rlb_store.sv
module rlb_store #(
    parameter int TAG_W  = 28,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [TAG_W-1:0]  pend_tag_in,
    input  logic [IDX_W-1:0]  pend_crit_in,
    input  logic              beat_we,
    input  logic [IDX_W-1:0]  beat_cnt,
    input  logic [WORD_W-1:0] beat_data,
    input  logic              commit,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [WORD_W-1:0] cpu_data,
    output logic [LINE_W-1:0] line_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic              valid_o,
    output logic              dirty_o
);
    logic [TAG_W-1:0] p_tag;
    logic [IDX_W-1:0] p_crit;
    logic [IDX_W-1:0] beat_idx;

    assign beat_idx = p_crit + beat_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_tag  <= '0;
            p_crit <= '0;
        end else if (start_ok) begin
            p_tag  <= pend_tag_in;
            p_crit <= pend_crit_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            dirty_o <= 1'b0;
            tag_o   <= '0;
        end else begin
            if (start_ok)    valid_o <= 1'b0;
            else if (commit) valid_o <= 1'b1;
            if (commit)      dirty_o <= 1'b0;
            else if (cpu_we) dirty_o <= 1'b1;
            if (commit)      tag_o   <= p_tag;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                   word_q <= '0;
            else if (beat_we && beat_idx == IDX_W'(g))    word_q <= beat_data;
            else if (cpu_we && cpu_idx == IDX_W'(g))      word_q <= cpu_data;
        end
        assign line_o[g*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/rlb_lookup.sv
module rlb_lookup #(
    parameter int TAG_W  = 28,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic              lk_valid,
    input  logic              lk_cacheable,
    input  logic [TAG_W-1:0]  lk_tag,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic              arr_hit,
    input  logic              cache_en,
    input  logic              hold,
    input  logic              buf_valid,
    input  logic [TAG_W-1:0]  buf_tag,
    input  logic [LINE_W-1:0] line,
    output logic              buf_hit,
    output logic              miss,
    output logic [WORD_W-1:0] rdata
);
    logic cacheable_req;

    always_comb begin
        cacheable_req = lk_valid && lk_cacheable;
        buf_hit       = cacheable_req && hold && buf_valid && (lk_tag == buf_tag);
        miss          = cacheable_req && !buf_hit && !(cache_en && arr_hit);
        rdata         = buf_hit ? line[lk_idx*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/refill_line_buffer.sv
module refill_line_buffer #(
    parameter int WADDR_W = 30,
    parameter int WORD_W  = 32,
    parameter int WORDS   = 4,
    localparam int IDX_W  = $clog2(WORDS),
    localparam int TAG_W  = WADDR_W - IDX_W,
    localparam int LINE_W = WORD_W * WORDS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cache_en,
    input  logic               lk_valid,
    input  logic               lk_write,
    input  logic               lk_cacheable,
    input  logic [WADDR_W-1:0] lk_waddr,
    input  logic [WORD_W-1:0]  lk_wdata,
    input  logic               arr_hit,
    output logic               lk_buf_hit,
    output logic               lk_miss,
    output logic [WORD_W-1:0]  lk_rdata,
    input  logic               fill_start,
    input  logic [WADDR_W-1:0] fill_waddr,
    input  logic               fill_valid,
    input  logic [WORD_W-1:0]  fill_data,
    output logic               fwd_valid,
    output logic [WORD_W-1:0]  fwd_data,
    output logic               busy,
    output logic               line_wr_en,
    output logic [TAG_W-1:0]   line_wr_tag,
    output logic [LINE_W-1:0]  line_wr_data,
    output logic               line_wr_dirty
);
    logic [IDX_W-1:0]  beat_cnt;
    logic              start_ok, beat_we, commit, xfer_en, hold;
    logic [LINE_W-1:0] line;
    logic [TAG_W-1:0]  buf_tag;
    logic              buf_valid, buf_dirty;
    logic              cpu_we;

    rlb_ctrl #(.WORDS(WORDS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cache_en   (cache_en),
        .fill_start (fill_start),
        .fill_valid (fill_valid),
        .line_dirty (buf_dirty),
        .beat_cnt   (beat_cnt),
        .start_ok   (start_ok),
        .beat_we    (beat_we),
        .commit     (commit),
        .xfer_en    (xfer_en),
        .fwd_valid  (fwd_valid),
        .busy       (busy),
        .hold       (hold)
    );

    assign cpu_we = lk_valid && lk_write && lk_buf_hit;

    rlb_store #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_ok     (start_ok),
        .pend_tag_in  (fill_waddr[WADDR_W-1:IDX_W]),
        .pend_crit_in (fill_waddr[IDX_W-1:0]),
        .beat_we      (beat_we),
        .beat_cnt     (beat_cnt),
        .beat_data    (fill_data),
        .commit       (commit),
        .cpu_we       (cpu_we),
        .cpu_idx      (lk_waddr[IDX_W-1:0]),
        .cpu_data     (lk_wdata),
        .line_o       (line),
        .tag_o        (buf_tag),
        .valid_o      (buf_valid),
        .dirty_o      (buf_dirty)
    );

    rlb_lookup #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_lookup (
        .lk_valid     (lk_valid),
        .lk_cacheable (lk_cacheable),
        .lk_tag       (lk_waddr[WADDR_W-1:IDX_W]),
        .lk_idx       (lk_waddr[IDX_W-1:0]),
        .arr_hit      (arr_hit),
        .cache_en     (cache_en),
        .hold         (hold),
        .buf_valid    (buf_valid),
        .buf_tag      (buf_tag),
        .line         (line),
        .buf_hit      (lk_buf_hit),
        .miss         (lk_miss),
        .rdata        (lk_rdata)
    );

    assign fwd_data      = fill_data;
    assign line_wr_en    = xfer_en;
    assign line_wr_tag   = buf_tag;
    assign line_wr_data  = line;
    assign line_wr_dirty = xfer_en && buf_dirty;
endmodule

// File: rtl/rlb_checker.sv
module rlb_checker (
    input logic clk,
    input logic rst_n,
    input logic cache_en,
    input logic fill_start,
    input logic line_wr_en,
    input logic line_wr_dirty,
    input logic fwd_valid,
    input logic lk_buf_hit,
    input logic lk_miss,
    input logic busy
);
    // R5: the push lasts exactly one cycle
    a_r5_push_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_en |=> !line_wr_en);

    // R5: a push only follows a refill start
    a_r5_push_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        line_wr_en |-> $past(fill_start));

    // R6: hit and miss never together
    a_r6_hit_miss_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_buf_hit && lk_miss));

    // R3: only one beat per refill is forwarded
    a_r3_fwd_once: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid);

    // R4: no array write while a beat is captured
    a_r4_no_wr_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !line_wr_en);

    // R9: without an array only modified lines leave the buffer
    a_r9_nocache_dirty_only: assert property (@(posedge clk) disable iff (!rst_n)
        (line_wr_en && !cache_en) |-> line_wr_dirty);

    // R11: no buffer hit during push or refill
    a_r11_busy_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !lk_buf_hit);
endmodule

bind refill_line_buffer rlb_checker u_rlb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cache_en      (cache_en),
    .fill_start    (fill_start),
    .line_wr_en    (line_wr_en),
    .line_wr_dirty (line_wr_dirty),
    .fwd_valid     (fwd_valid),
    .lk_buf_hit    (lk_buf_hit),
    .lk_miss       (lk_miss),
    .busy          (busy)
);

// File: tb/test_refill_line_buffer.sv
module test_refill_line_buffer;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         cache_en, lk_valid, lk_write, lk_cacheable, arr_hit;
    logic [29:0]  lk_waddr, fill_waddr;
    logic [31:0]  lk_wdata, fill_data, lk_rdata, fwd_data;
    logic         lk_buf_hit, lk_miss, fill_start, fill_valid, fwd_valid, busy;
    logic         line_wr_en, line_wr_dirty;
    logic [27:0]  line_wr_tag;
    logic [127:0] line_wr_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        m_valid, m_dirty;
    logic [27:0] m_tag;
    logic [31:0] m_word [4];

    always #5 clk = ~clk;

    refill_line_buffer i_refill_line_buffer (
        .clk(clk), .rst_n(rst_n), .cache_en(cache_en),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_cacheable(lk_cacheable),
        .lk_waddr(lk_waddr), .lk_wdata(lk_wdata), .arr_hit(arr_hit),
        .lk_buf_hit(lk_buf_hit), .lk_miss(lk_miss), .lk_rdata(lk_rdata),
        .fill_start(fill_start), .fill_waddr(fill_waddr), .fill_valid(fill_valid),
        .fill_data(fill_data), .fwd_valid(fwd_valid), .fwd_data(fwd_data),
        .busy(busy), .line_wr_en(line_wr_en), .line_wr_tag(line_wr_tag),
        .line_wr_data(line_wr_data), .line_wr_dirty(line_wr_dirty)
    );

    task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    function automatic logic [31:0] pat(input logic [27:0] tg, input int k);
        return {4'hA, tg[19:0], 4'h5, 2'b00, 2'(k)};
    endfunction

    task automatic lookup(input logic [27:0] tg, input int idx, input bit wr,
                          input logic [31:0] wd, input bit cach, input bit ah);
        bit exp_hit, exp_miss;
        @(negedge clk);
        lk_valid = 1'b1; lk_write = wr; lk_wdata = wd; lk_cacheable = cach;
        arr_hit = ah; lk_waddr = {tg, 2'(idx)};
        #1;
        exp_hit  = cach && m_valid && (tg == m_tag);
        exp_miss = cach && !exp_hit && !(cache_en && ah);
        if (!cach) begin
            chk("R7 noncacheable hit", 128'(lk_buf_hit), 128'(0));
            chk("R7 noncacheable miss", 128'(lk_miss), 128'(0));
        end else begin
            chk("R6 buffer hit", 128'(lk_buf_hit), 128'(exp_hit));
            chk(cache_en ? "R6 miss" : "R9 miss arr_hit ignored", 128'(lk_miss), 128'(exp_miss));
        end
        if (exp_hit && !wr) chk("R2 read data", 128'(lk_rdata), 128'(m_word[idx]));
        @(posedge clk);
        #1;
        lk_valid = 1'b0; lk_write = 1'b0;
        if (exp_hit && wr) begin
            m_word[idx] = wd;
            m_dirty = 1'b1;
        end
    endtask

    task automatic read_all(input string tagname);
        for (int w = 0; w < 4; w++) begin
            @(negedge clk);
            lk_valid = 1'b1; lk_write = 1'b0; lk_cacheable = 1'b1; arr_hit = 1'b0;
            lk_waddr = {m_tag, 2'(w)};
            #1;
            chk({tagname, " word held"}, 128'(lk_rdata), 128'(m_word[w]));
        end
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic do_fill(input logic [27:0] tg, input int crit);
        bit exp_x;
        logic [27:0] old_tag;
        old_tag = m_tag;
        exp_x = m_valid && (cache_en || m_dirty);
        @(negedge clk);
        fill_start = 1'b1; fill_waddr = {tg, 2'(crit)};
        @(negedge clk);
        fill_start = 1'b0;
        #1;
        chk("R11 busy after start", 128'(busy), 128'(1));
        if (cache_en) chk("R5 push enable", 128'(line_wr_en), 128'(exp_x));
        else          chk("R9 push only if dirty", 128'(line_wr_en), 128'(exp_x));
        if (exp_x) begin
            chk("R5 push tag", 128'(line_wr_tag), 128'(m_tag));
            chk("R5 push data", line_wr_data, {m_word[3], m_word[2], m_word[1], m_word[0]});
            chk("R8 push dirty", 128'(line_wr_dirty), 128'(m_dirty));
            @(negedge clk);
        end
        m_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            fill_valid = 1'b1; fill_data = pat(tg, k);
            lk_valid = (k == 1); lk_write = 1'b0; lk_cacheable = 1'b1; arr_hit = 1'b0;
            lk_waddr = {old_tag, 2'(crit)};
            #1;
            chk("R3 forward valid", 128'(fwd_valid), 128'(k == 0));
            if (k == 0) chk("R3 forward data", 128'(fwd_data), 128'(pat(tg, 0)));
            chk("R4 no write on beat", 128'(line_wr_en), 128'(0));
            if (k == 1) chk("R11 no hit while busy", 128'(lk_buf_hit), 128'(0));
            m_word[(crit + k) % 4] = pat(tg, k);
            @(negedge clk);
        end
        fill_valid = 1'b0; lk_valid = 1'b0;
        #1;
        chk("R11 busy cleared", 128'(busy), 128'(0));
        m_valid = 1'b1; m_tag = tg; m_dirty = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
    end

    initial begin
        rst_n = 1'b0; cache_en = 1'b1; lk_valid = 1'b0; lk_write = 1'b0;
        lk_cacheable = 1'b0; arr_hit = 1'b0; lk_waddr = '0; lk_wdata = '0;
        fill_start = 1'b0; fill_waddr = '0; fill_valid = 1'b0; fill_data = '0;
        m_valid = 1'b0; m_dirty = 1'b0; m_tag = '0;
        for (int i = 0; i < 4; i++) m_word[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 busy", 128'(busy), 128'(0));
        chk("R1 line_wr_en", 128'(line_wr_en), 128'(0));
        chk("R1 fwd_valid", 128'(fwd_valid), 128'(0));
        lookup(28'h0, 0, 1'b0, 32'h0, 1'b1, 1'b0);

        for (int ce = 1; ce >= 0; ce--) begin
            cache_en = ce[0];
            for (int t = 0; t < 4; t++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [27:0] tg;
                    tg = 28'h0123000 + 28'(ce * 16 + t * 4 + c);
                    do_fill(tg, c);
                    for (int w = 0; w < 4; w++)
                        lookup(tg, w, 1'b0, 32'h0, 1'b1, w[0]);
                    lookup(tg + 28'h40, c, 1'b0, 32'h0, 1'b1, 1'b1);
                    lookup(tg + 28'h40, c, 1'b0, 32'h0, 1'b1, 1'b0);
                    lookup(tg, c, 1'b0, 32'h0, 1'b0, 1'b1);
                    // R10: write to another tag leaves the line alone
                    lookup(tg + 28'h80, c, 1'b1, 32'hDEAD0000 + 32'(c), 1'b1, 1'b0);
                    read_all("R10");
                    if (c[0]) begin
                        lookup(tg, (c + 1) % 4, 1'b1, 32'h5A5A0000 + 32'(t * 4 + c), 1'b1, 1'b0);
                        read_all("R8");
                    end
                end
            end
        end
        repeat (2) @(negedge clk);
        report();
    end
endmodule